// File: doc/BRIEF.md
# Serial Register-Access Bridge

This block is a serial-peripheral slave that lets an external host read and write 32-bit registers on an internal request/acknowledge bus. Each frame, framed by an active-low chip select, begins with a 24-bit header. The first header bit is a write flag and the remaining 23 bits are a word index. A 32-bit payload follows the header. On reads, a programmable number of padding bytes sits between the header and the payload. These bytes give the internal bus time to answer before the first data bit has to leave the block.

Two registers live inside the bridge and never reach the internal bus. A control register selects the byte order and bit order of the payload. The header is always sent most significant bit first, whatever that setting is. A config/status register holds the read padding count, a sticky underrun flag and a fixed interface number. The serial pins are sampled in the system clock domain: SCLK, chip select and MOSI are taken to be synchronous to `clk` and much slower than it.

Top module: `spi_reg_bridge`

## Requirements
- R1: The 24-bit header is shifted in most significant bit first in every payload format. The bus byte address equals the 23-bit word index shifted left by two.
- R2: The first header bit (0x80 of the first byte) set marks a write. Clear marks a read, and a read never issues a bus write.
- R3: After the 32nd payload bit of a write frame, one bus write carries the decoded payload. `bus_req` and the address hold until `bus_ack`.
- R4: If chip select is released before the last payload bit of a write frame, no write takes place.
- R5: A read issues its bus request when the last header bit arrives. MISO then returns N padding bytes of zeros and then the 32 data bits, driven on falling SCLK edges and valid at the rising ones.
- R6: Payload format field fmt: bit 0 set sends the most significant byte first (clear: least significant byte first). Bit 1 set sends each byte least significant bit first (clear: most significant bit first).
- R7: The control register sits at word index LOCAL_WIDX (default 0x7FFFF0). A write loads fmt from bits 1:0 of the decoded payload. A read returns fmt in bits 1:0 of every byte with all other bits zero. Neither access touches the bus.
- R8: The config/status register sits at word index LOCAL_WIDX+1. Bits 3:0 hold the padding count N (read/write), bits 31:24 read the interface number IF_ID (default 2), and bit 16 is the underrun flag. All other bits read zero.
- R9: If read data is not ready at the falling SCLK edge that must drive its first bit, bit 16 sets and the frame returns all zeros. The flag stays set until the config/status register is written.
- R10: After reset fmt is 00, N is 0, the underrun flag is clear, `bus_req` is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_req | output | 1 | Internal bus request, held until acknowledge |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 25 | Internal bus byte address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge, one cycle |
| bus_rdata | input | 32 | Internal bus read data, valid with acknowledge |

## Verification
The assertions take for granted that the internal bus answers each request with exactly one acknowledge pulse. They also assume the host starts no new frame until the previous bus access has finished, and that the padding count is not rewritten in the middle of a read frame. The bench keeps each SCLK half-period at four system clocks. Its memory model waits for the request to drop before it can answer again. After every frame the bench waits for `bus_req` to go low. Read latency stays well inside the padding window, except in the directed underrun case, which uses zero padding and a latency far longer than half an SCLK period.

// File: rtl/spib_pkg.sv
package spib_pkg;

   localparam int WORD_W = 32;

   // Data bit index carried by wire slot k (slot 0 leaves first) for format fmt.
   function automatic int wire_src(input int k, input logic [1:0] fmt);
      int grp;
      int pos;
      int byt;
      int bt;
      grp = k / 8;
      pos = k % 8;
      byt = fmt[0] ? (3 - grp) : grp;
      bt  = fmt[1] ? pos : (7 - pos);
      return byt * 8 + bt;
   endfunction

   // Register value to wire order: result bit 31 leaves first.
   function automatic logic [WORD_W-1:0] to_wire(input logic [WORD_W-1:0] d,
                                                 input logic [1:0] fmt);
      logic [WORD_W-1:0] w;
      for (int k = 0; k < WORD_W; k++) w[WORD_W-1-k] = d[wire_src(k, fmt)];
      return w;
   endfunction

   // Wire order back to register value.
   function automatic logic [WORD_W-1:0] from_wire(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] fmt);
      logic [WORD_W-1:0] d;
      for (int k = 0; k < WORD_W; k++) d[wire_src(k, fmt)] = w[WORD_W-1-k];
      return d;
   endfunction

endpackage

// File: rtl/spib_frame.sv
module spib_frame #(
   parameter int ADDR_BITS = 24,
   parameter int DATA_W    = 32,
   parameter int PAD_W     = 4,
   parameter int CNT_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk,
   input  logic                 cs_n,
   input  logic                 mosi,
   input  logic [PAD_W-1:0]     pad_n,
   input  logic [DATA_W-1:0]    rd_word,
   input  logic                 rd_ready,
   output logic                 miso,
   output logic                 addr_done,
   output logic [ADDR_BITS-1:0] hdr_now,
   output logic                 wr_done,
   output logic [DATA_W-1:0]    rx_now,
   output logic                 underrun_set
);
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_BITS - 1);
   localparam logic [CNT_W-1:0] HDR_LEN  = CNT_W'(ADDR_BITS);
   localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(ADDR_BITS + DATA_W - 1);

   logic                sclk_d;
   logic [CNT_W-1:0]    cnt;
   logic [DATA_W-2:0]   sr;
   logic [DATA_W-1:0]   tx;
   logic                wr_q;
   logic                rise, fall, in_rd, load;
   logic [CNT_W-1:0]    data_start;

   assign rise       = !cs_n && sclk && !sclk_d;
   assign fall       = !cs_n && !sclk && sclk_d;
   assign data_start = HDR_LEN + (CNT_W'(pad_n) << 3);
   assign in_rd      = !wr_q && (cnt >= HDR_LEN);
   assign load       = fall && in_rd && (cnt == data_start);

   assign addr_done    = rise && (cnt == HDR_LAST);
   assign hdr_now      = {sr[ADDR_BITS-2:0], mosi};
   assign wr_done      = rise && wr_q && (cnt == WR_LAST);
   assign rx_now       = {sr, mosi};
   assign underrun_set = load && !rd_ready;
   assign miso         = tx[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cnt    <= '0;
         sr     <= '0;
         tx     <= '0;
         wr_q   <= 1'b0;
      end else begin
         sclk_d <= sclk;
         if (cs_n) begin
            cnt  <= '0;
            sr   <= '0;
            tx   <= '0;
            wr_q <= 1'b0;
         end else begin
            if (rise) begin
               sr <= {sr[DATA_W-3:0], mosi};
               if (cnt != '1) cnt <= cnt + 1'b1;
               if (cnt == '0) wr_q <= mosi;
            end
            if (load)
               tx <= rd_ready ? rd_word : '0;
            else if (fall && in_rd)
               tx <= tx << 1;
         end
      end
   end

   AST_PAD_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !wr_q && cnt >= HDR_LEN && cnt < data_start) |-> !miso); // R5

   AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_set |=> !miso); // R9

endmodule

// File: rtl/spib_regs.sv
module spib_regs #(
   parameter int DATA_W = 32,
   parameter int PAD_W  = 4,
   parameter int IF_ID  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_cfg,
   input  logic [1:0]        ctrl_in,
   input  logic [PAD_W-1:0]  pad_in,
   input  logic              underrun_set,
   output logic [1:0]        fmt,
   output logic [PAD_W-1:0]  pad_n,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [DATA_W-1:0] cfg_rd
);
   localparam int NBYTES = DATA_W / 8;

   logic underrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt      <= 2'b00;
         pad_n    <= '0;
         underrun <= 1'b0;
      end else begin
         if (wr_ctrl) fmt   <= ctrl_in;
         if (wr_cfg)  pad_n <= pad_in;
         if (underrun_set)  underrun <= 1'b1;
         else if (wr_cfg)   underrun <= 1'b0;
      end
   end

   // Format code mirrored into every byte lane.
   for (genvar b = 0; b < NBYTES; b++) begin : g_mirror
      assign ctrl_rd[8*b +: 8] = {6'b000000, fmt};
   end

   always_comb begin
      cfg_rd                 = '0;
      cfg_rd[31:24]          = 8'(IF_ID);
      cfg_rd[16]             = underrun;
      cfg_rd[PAD_W-1:0]      = pad_n;
   end

   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !wr_cfg) |=> underrun); // R9

endmodule

// File: rtl/spib_bus.sv
module spib_bus #(
   parameter int BA_W   = 25,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_wr,
   input  logic [BA_W-1:0]   addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              bus_ack,
   output logic              bus_req,
   output logic              bus_we,
   output logic [BA_W-1:0]   bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              rd_done
);
   assign rd_done = bus_req && bus_ack && !bus_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else if (!bus_req) begin
         if (start_rd || start_wr) begin
            bus_req   <= 1'b1;
            bus_we    <= start_wr;
            bus_addr  <= addr_in;
            bus_wdata <= wdata_in;
         end
      end else if (bus_ack) begin
         bus_req <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R3

   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_rd && start_wr)); // R2

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
   parameter int ADDR_BITS  = 24,
   parameter int DATA_W     = 32,
   parameter int PAD_W      = 4,
   parameter int IF_ID      = 2,
   parameter int LOCAL_WIDX = 23'h7FFFF0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sclk,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   output logic                 bus_req,
   output logic                 bus_we,
   output logic [ADDR_BITS:0]   bus_addr,
   output logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_ack,
   input  logic [DATA_W-1:0]    bus_rdata
);
   import spib_pkg::*;

   localparam int W     = ADDR_BITS - 1;
   localparam int BA_W  = W + 2;
   localparam int CNT_W = $clog2(ADDR_BITS + 8 * ((1 << PAD_W) - 1) + DATA_W + 1);
   localparam logic [W-1:0] LOC = W'(LOCAL_WIDX);

   if (DATA_W != WORD_W) begin : g_bad_data
      $error("spi_reg_bridge: DATA_W must be 32");
   end
   if (ADDR_BITS < 2 || ADDR_BITS > DATA_W) begin : g_bad_addr
      $error("spi_reg_bridge: ADDR_BITS out of range");
   end
   if (PAD_W < 1 || PAD_W > 16) begin : g_bad_pad
      $error("spi_reg_bridge: PAD_W out of range");
   end
   if (IF_ID < 0 || IF_ID > 255) begin : g_bad_id
      $error("spi_reg_bridge: IF_ID must fit 8 bits");
   end

   logic                 addr_done, wr_done, underrun_set;
   logic [ADDR_BITS-1:0] hdr_now;
   logic [DATA_W-1:0]    rx_now, wdec;
   logic [1:0]           fmt;
   logic [PAD_W-1:0]     pad_n;
   logic [DATA_W-1:0]    ctrl_rd, cfg_rd, rd_word;
   logic                 rd_ready, rd_done;
   logic [W-1:0]         widx, widx_q;
   logic                 hit_now, loc_q, is_write;
   logic                 wr_ctrl, wr_cfg, start_rd, start_wr;
   logic [BA_W-1:0]      addr_in;

   assign widx     = hdr_now[W-1:0];
   assign is_write = hdr_now[ADDR_BITS-1];
   assign hit_now  = (widx[W-1:1] == LOC[W-1:1]);
   assign wdec     = from_wire(rx_now, fmt);
   assign wr_ctrl  = wr_done && loc_q && !widx_q[0];
   assign wr_cfg   = wr_done && loc_q && widx_q[0];
   assign start_wr = wr_done && !loc_q;
   assign start_rd = addr_done && !is_write && !hit_now;
   assign addr_in  = start_wr ? {widx_q, 2'b00} : {widx, 2'b00};

   spib_frame #(.ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W), .PAD_W(PAD_W), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .pad_n(pad_n), .rd_word(rd_word), .rd_ready(rd_ready), .miso(spi_miso),
      .addr_done(addr_done), .hdr_now(hdr_now), .wr_done(wr_done), .rx_now(rx_now),
      .underrun_set(underrun_set));

   spib_regs #(.DATA_W(DATA_W), .PAD_W(PAD_W), .IF_ID(IF_ID)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
      .ctrl_in(wdec[1:0]), .pad_in(wdec[PAD_W-1:0]), .underrun_set(underrun_set),
      .fmt(fmt), .pad_n(pad_n), .ctrl_rd(ctrl_rd), .cfg_rd(cfg_rd));

   spib_bus #(.BA_W(BA_W), .DATA_W(DATA_W)) u_bus (
      .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
      .addr_in(addr_in), .wdata_in(wdec), .bus_ack(bus_ack), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_done(rd_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx_q   <= '0;
         loc_q    <= 1'b0;
         rd_word  <= '0;
         rd_ready <= 1'b0;
      end else begin
         if (addr_done) begin
            widx_q <= widx;
            loc_q  <= hit_now;
         end
         if (spi_cs_n) begin
            rd_ready <= 1'b0;
         end else if (addr_done && !is_write && hit_now) begin
            rd_word  <= to_wire(widx[0] ? cfg_rd : ctrl_rd, fmt);
            rd_ready <= 1'b1;
         end else if (rd_done) begin
            rd_word  <= to_wire(bus_rdata, fmt);
            rd_ready <= 1'b1;
         end
      end
   end

   AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && bus_we) |-> $past(!spi_cs_n)); // R4

   AST_LOCAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_done && hit_now && !bus_req) |=> !bus_req); // R7

endmodule

// File: tb/tb_spi_reg_bridge.sv
module tb_spi_reg_bridge;

   localparam int H = 4;
   localparam logic [22:0] LOCW = 23'h7FFFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic        bus_req, bus_we, bus_ack = 1'b0;
   logic [24:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata = '0;

   int tests = 0, fails = 0;
   int mem_lat = 2;
   int wr_cnt = 0, rd_cnt = 0;
   logic [24:0] last_addr;
   logic [31:0] last_data;
   logic [31:0] mem [logic [24:0]];

   always #4 clk = ~clk;

   spi_reg_bridge dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   // Memory model behind the internal bus.
   initial forever begin
      @(negedge clk);
      if (bus_req) begin
         repeat (mem_lat) @(negedge clk);
         if (bus_we) begin
            mem[bus_addr] = bus_wdata;
            last_addr = bus_addr;
            last_data = bus_wdata;
            wr_cnt++;
         end else begin
            bus_rdata = mem.exists(bus_addr) ? mem[bus_addr] : {7'h55, bus_addr};
            rd_cnt++;
         end
         bus_ack = 1'b1;
         @(negedge clk);
         bus_ack = 1'b0;
      end
   end

   // Wire image of a value: byte sequence chosen by fmt[0], bit sequence by fmt[1].
   function automatic logic [31:0] enc(input logic [31:0] d, input logic [1:0] f);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b;
         b = f[0] ? d[8*(3-i) +: 8] : d[8*i +: 8];
         for (int j = 0; j < 8; j++) w[31-8*i-j] = f[1] ? b[j] : b[7-j];
      end
      return w;
   endfunction

   function automatic logic [31:0] dec(input logic [31:0] w, input logic [1:0] f);
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         int bn;
         bn = f[0] ? 3 - i : i;
         for (int j = 0; j < 8; j++) d[8*bn + (f[1] ? j : 7-j)] = w[31-8*i-j];
      end
      return d;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [22:0] widx, input logic [31:0] wire_out,
                       input int pad, input int limit,
                       output logic [31:0] wire_in, output int pad_ones);
      logic [23:0] hdr;
      int total;
      hdr = {wr, widx};
      total = 24 + (wr ? 0 : 8 * pad) + 32;
      if (limit > 0) total = limit;
      wire_in = '0;
      pad_ones = 0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < total; i++) begin
         if (i < 24) mosi = hdr[23-i];
         else if (wr) mosi = wire_out[31-(i-24)];
         else mosi = 1'b0;
         repeat (H) @(negedge clk);
         if (!wr && i >= 24 && i < 24 + 8*pad && miso) pad_ones++;
         if (!wr && i >= 24 + 8*pad) wire_in[31-(i-24-8*pad)] = miso;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (4) @(negedge clk);
      while (bus_req) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   logic [1:0] cur = 2'b00;
   int cur_pad = 0;

   task automatic wr_reg(input logic [22:0] widx, input logic [31:0] val);
      logic [31:0] dummy;
      int po;
      xfer(1'b1, widx, enc(val, cur), 0, 0, dummy, po);
   endtask

   task automatic rd_reg(input logic [22:0] widx, output logic [31:0] val, output int po);
      logic [31:0] w;
      xfer(1'b0, widx, '0, cur_pad, 0, w, po);
      val = dec(w, cur);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v, d;
      logic [22:0] a;
      int po, w0, r0;
      void'($urandom(32'h5EED_1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Reset state
      check("R10 miso after reset", {31'b0, miso}, 32'h0);
      check("R10 bus_req after reset", {31'b0, bus_req}, 32'h0);
      rd_reg(LOCW, v, po);
      check("R10 R7 control default", v, 32'h0);
      rd_reg(LOCW + 23'd1, v, po);
      check("R10 R8 cfg default", v, 32'h0200_0000);

      // Padding count read/write
      wr_reg(LOCW + 23'd1, 32'h0000_0001); cur_pad = 1;
      rd_reg(LOCW + 23'd1, v, po);
      check("R8 cfg pad readback", v, 32'h0200_0001);

      // Random writes and reads across formats
      for (int it = 0; it < 20; it++) begin
         logic [1:0] f;
         f = 2'($urandom % 4);
         wr_reg(LOCW, {4{6'b0, f}}); cur = f;
         cur_pad = 1 + int'($urandom % 2);
         wr_reg(LOCW + 23'd1, 32'(cur_pad));
         a = 23'($urandom) & 23'h3FFFFF;
         d = $urandom;
         mem_lat = int'($urandom % 12);
         w0 = wr_cnt;
         wr_reg(a, d);
         check("R3 one bus write", 32'(wr_cnt - w0), 32'd1);
         check("R1 bus byte address", {7'b0, last_addr}, {7'b0, a, 2'b00});
         check("R6 decoded write data", last_data, d);
         w0 = wr_cnt; r0 = rd_cnt;
         rd_reg(a, v, po);
         check("R5 read data", v, d);
         check("R5 padding reads zero", 32'(po), 32'd0);
         check("R2 read issues no write", 32'(wr_cnt - w0), 32'd0);
         check("R5 one bus read", 32'(rd_cnt - r0), 32'd1);
         if (it % 4 == 0) begin
            r0 = rd_cnt;
            rd_reg(LOCW, v, po);
            check("R7 control mirrored", v, {4{6'b0, f}});
            check("R7 local read stays off bus", 32'(rd_cnt - r0), 32'd0);
         end
      end

      // Aborted writes
      mem_lat = 1;
      w0 = wr_cnt;
      begin
         logic [31:0] dm;
         xfer(1'b1, 23'h000123, enc(32'hDEAD_BEEF, cur), 0, 24 + 20, dm, po);
         xfer(1'b1, 23'h000124, enc(32'hDEAD_BEEF, cur), 0, 10, dm, po);
         xfer(1'b1, 23'h000125, enc(32'hDEAD_BEEF, cur), 0, 24 + 31, dm, po);
      end
      check("R4 aborted writes issue nothing", 32'(wr_cnt - w0), 32'd0);
      wr_reg(23'h000126, 32'h0BAD_F00D);
      check("R4 next full frame writes", last_data, 32'h0BAD_F00D);

      // Underrun with zero padding and slow bus
      wr_reg(LOCW + 23'd1, 32'h0); cur_pad = 0;
      mem_lat = 30;
      rd_reg(23'h000126, v, po);
      check("R9 underrun returns zero", v, 32'h0);
      mem_lat = 1;
      rd_reg(LOCW + 23'd1, v, po);
      check("R9 underrun flag set", v, 32'h0201_0000);
      rd_reg(23'h000126, v, po);
      check("R9 fast read ok with no padding", v, 32'h0BAD_F00D);
      rd_reg(LOCW + 23'd1, v, po);
      check("R9 underrun flag sticky", v, 32'h0201_0000);
      wr_reg(LOCW + 23'd1, 32'h0000_0002); cur_pad = 2;
      rd_reg(LOCW + 23'd1, v, po);
      check("R9 cfg write clears flag", v, 32'h0200_0002);

      // Reset in the middle of a configured state
      wr_reg(LOCW, {4{8'h03}}); cur = 2'b11;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
      cur = 2'b00; cur_pad = 0;
      repeat (2) @(negedge clk);
      check("R10 miso after mid reset", {31'b0, miso}, 32'h0);
      rd_reg(LOCW, v, po);
      check("R10 control cleared", v, 32'h0);
      rd_reg(LOCW + 23'd1, v, po);
      check("R10 cfg cleared", v, 32'h0200_0000);

      finish_run();
   end

endmodule